// File: doc/BRIEF.md
# PWM Period and High-Time Capture Unit

This block times a digital pulse-width-modulated signal using a counter that runs at the system clock, with no prescaler. Each rising edge of the measured signal ends one cycle. That edge yields the period in clock cycles and restarts the counter from zero. Each falling edge yields the high time, measured from the last rising edge. Two physical pins feed the block. A swap select picks which pin supplies the rising edges and which supplies the falling edges. Normally both pins are wired to the same signal.

The mode select chooses one of three behaviours:

- **Idle** holds the counter at zero.
- **Continuous** publishes the latest period together with the high time of that same cycle, as a matched pair, with a one-cycle strobe.
- **Burst** first throws away the first partial cycle. It then adds the period and high time of a requested number of whole cycles into wide totals, stops, and offers a report on a valid/ready output. The report holds the cycle count, both totals and the counter clock frequency in MHz, so the receiver can turn counts into time.

The report is the only data stream. It obeys valid/ready back-pressure: once raised, `rpt_valid` and every report field stay unchanged until the cycle in which `rpt_ready` is high. All other pins are plain levels.

Top module: `pwm_meter`

## Requirements
- R1: After reset, `pair_period`, `pair_high`, `pair_stb`, `busy` and `rpt_valid` are all zero.
- R2: In continuous mode (`mode_sel` = 1), each rising edge updates the published pair and pulses `pair_stb` for one cycle. `pair_period` is the number of clock cycles since the previous rising edge. `pair_high` is the number of cycles from that previous rising edge to the falling edge between the two rising edges. The update shows on the second clock edge after the edge that first samples the new pin level.
- R3: Switching into continuous mode clears `pair_period` and `pair_high` to zero on the clock edge that applies the switch.
- R4: In idle mode (`mode_sel` = 0 or 3), activity on the pins changes neither published value, raises no strobe and produces no report.
- R5: With `swap_sel` = 0, rising edges come from `pin_a` and falling edges from `pin_b`. With `swap_sel` = 1, rising edges come from `pin_b` and falling edges from `pin_a`.
- R6: In burst mode (`mode_sel` = 2), the first rising edge after entry is not counted. Each later rising edge adds the period and the latched high time to two totals and increments the count. When the count reaches the target sampled at entry, `rpt_valid` rises with the count and totals, and `busy` stays high until the report is taken.
- R7: While `rpt_valid` is high and `rpt_ready` is low, the report fields stay stable. The cycle after a handshake, `rpt_valid` and `busy` are both low and the block is idle.
- R8: Holding `mode_sel` at its current value has no effect. After a burst completes, a new burst starts only when `mode_sel` changes to 2 again.
- R9: A burst target of zero completes after one counted cycle.
- R10: A change of `mode_sel` while a report is pending is deferred. It takes effect only after the handshake.
- R11: `rpt_clk_mhz` equals the `CLK_MHZ` parameter (200 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 1 | First measured pin (asynchronous) |
| pin_b | input | 1 | Second measured pin (asynchronous) |
| swap_sel | input | 1 | Selects which pin supplies rising and which supplies falling edges |
| mode_sel | input | 2 | 0 idle, 1 continuous, 2 burst, 3 idle |
| burst_target | input | BCNT_W | Whole cycles to sum in a burst, sampled at entry |
| pair_period | output | CNT_W | Last period in clock cycles |
| pair_high | output | CNT_W | High time matched to `pair_period` |
| pair_stb | output | 1 | One-cycle pulse when the pair updates |
| busy | output | 1 | Burst running or report pending |
| rpt_valid | output | 1 | Report available |
| rpt_ready | input | 1 | Report accepted by the receiver |
| rpt_count | output | BCNT_W | Cycles summed |
| rpt_period_sum | output | ACC_W | Total of the periods |
| rpt_high_sum | output | ACC_W | Total of the high times |
| rpt_clk_mhz | output | MHZ_W | Counter clock frequency in MHz |

## Verification
The bench sweeps every period from 2 to 9 cycles against every legal high time. An off-by-one in the counter restart would show as every value being one too small. A pair taken from the wrong cycle would show stale high times right after a change. Bursts of length 0 to 4 are compared against totals computed by multiplication. A design that counted the partial first cycle would report one cycle too many or a short period in the sum. A design that re-armed while the mode stayed at burst would raise a second report. Back-pressure with a mode change held during the pending report catches fields that drift, and mode changes that are lost or applied early. A skewed second pin with both swap settings catches swapped or ignored edge sources.

// File: rtl/pwm_meter_pkg.sv
`timescale 1ns/1ps
package pwm_meter_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_BURST = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONT  = 2'd1,
    ST_BURST = 2'd2,
    ST_BUSY  = 2'd3
  } state_e;

  // Raw select code to mode; the unused code maps to idle.
  function automatic mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'd1:    return MODE_CONT;
      2'd2:    return MODE_BURST;
      default: return MODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/pwm_meter_edge.sv
`timescale 1ns/1ps
module pwm_meter_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_a,
  input  logic pin_b,
  input  logic swap,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [1:0] pins;
  logic [1:0] lvl_now;
  logic [1:0] lvl_old;

  assign pins = {pin_b, pin_a};

  for (genvar g = 0; g < 2; g++) begin : g_pin
    logic [CHAIN-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN-2:0], pins[g]};
    end
    assign lvl_now[g] = chain[CHAIN-2];
    assign lvl_old[g] = chain[CHAIN-1];
  end

  logic [1:0] up;
  logic [1:0] down;
  assign up   = lvl_now & ~lvl_old;
  assign down = ~lvl_now & lvl_old;

  always_comb begin
    if (swap) begin
      rise = up[1];
      fall = down[0];
    end else begin
      rise = up[0];
      fall = down[1];
    end
  end
endmodule

// File: rtl/pwm_meter_timer.sv
`timescale 1ns/1ps
module pwm_meter_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             rise,
  input  logic             fall,
  output logic             take,
  output logic [CNT_W-1:0] meas,
  output logic [CNT_W-1:0] hi_held
);
  logic [CNT_W-1:0] cnt;

  // Cycles elapsed including the current one; wraps modulo 2^CNT_W.
  assign meas = cnt + CNT_W'(1);
  assign take = run & rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hi_held <= '0;
    end else if (clear) begin
      cnt     <= '0;
      hi_held <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else begin
      if (rise) cnt <= '0;
      else      cnt <= meas;
      if (fall) hi_held <= meas;
    end
  end
endmodule

// File: rtl/pwm_meter_burst.sv
`timescale 1ns/1ps
module pwm_meter_burst #(
  parameter int CNT_W  = 32,
  parameter int BCNT_W = 16,
  parameter int ACC_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BCNT_W-1:0] target,
  input  logic              take,
  input  logic [CNT_W-1:0]  per,
  input  logic [CNT_W-1:0]  hi,
  output logic              done,
  output logic [BCNT_W-1:0] count,
  output logic [ACC_W-1:0]  psum,
  output logic [ACC_W-1:0]  hsum
);
  logic [BCNT_W-1:0] tgt_q;
  logic              skip_q;
  logic [BCNT_W-1:0] count_nx;
  logic              hit;

  assign count_nx = count + BCNT_W'(1);
  assign hit      = (count_nx == tgt_q) || (tgt_q == '0);
  assign done     = take && !skip_q && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      skip_q <= 1'b0;
      count  <= '0;
      psum   <= '0;
      hsum   <= '0;
    end else if (start) begin
      tgt_q  <= target;
      skip_q <= 1'b1;
      count  <= '0;
      psum   <= '0;
      hsum   <= '0;
    end else if (take) begin
      if (skip_q) begin
        skip_q <= 1'b0;
      end else begin
        count <= count_nx;
        psum  <= psum + ACC_W'(per);
        hsum  <= hsum + ACC_W'(hi);
      end
    end
  end
endmodule

// File: rtl/pwm_meter.sv
`timescale 1ns/1ps
module pwm_meter
  import pwm_meter_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int BCNT_W      = 16,
  parameter int ACC_W       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_MHZ     = 200,
  parameter int MHZ_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              swap_sel,
  input  logic [1:0]        mode_sel,
  input  logic [BCNT_W-1:0] burst_target,
  output logic [CNT_W-1:0]  pair_period,
  output logic [CNT_W-1:0]  pair_high,
  output logic              pair_stb,
  output logic              busy,
  output logic              rpt_valid,
  input  logic              rpt_ready,
  output logic [BCNT_W-1:0] rpt_count,
  output logic [ACC_W-1:0]  rpt_period_sum,
  output logic [ACC_W-1:0]  rpt_high_sum,
  output logic [MHZ_W-1:0]  rpt_clk_mhz
);
  state_e st;
  mode_e  mode_q;
  mode_e  req;
  logic   chg;
  logic   run;
  logic   rise, fall, take;
  logic   b_done;
  logic [CNT_W-1:0] meas;
  logic [CNT_W-1:0] hi_held;

  assign req = decode_mode(mode_sel);
  // Mode changes wait while a report is pending.
  assign chg = (req != mode_q) && (st != ST_BUSY);
  assign run = ((st == ST_CONT) || (st == ST_BURST)) && !chg;

  pwm_meter_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin_a(pin_a),
    .pin_b(pin_b),
    .swap (swap_sel),
    .rise (rise),
    .fall (fall)
  );

  pwm_meter_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .clear  (chg),
    .rise   (rise),
    .fall   (fall),
    .take   (take),
    .meas   (meas),
    .hi_held(hi_held)
  );

  pwm_meter_burst #(.CNT_W(CNT_W), .BCNT_W(BCNT_W), .ACC_W(ACC_W)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (chg && (req == MODE_BURST)),
    .target(burst_target),
    .take  (take && (st == ST_BURST)),
    .per   (meas),
    .hi    (hi_held),
    .done  (b_done),
    .count (rpt_count),
    .psum  (rpt_period_sum),
    .hsum  (rpt_high_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      mode_q      <= MODE_IDLE;
      pair_period <= '0;
      pair_high   <= '0;
      pair_stb    <= 1'b0;
      rpt_valid   <= 1'b0;
    end else begin
      pair_stb <= 1'b0;
      if (chg) begin
        mode_q <= req;
        case (req)
          MODE_CONT: begin
            st          <= ST_CONT;
            pair_period <= '0;
            pair_high   <= '0;
          end
          MODE_BURST: st <= ST_BURST;
          default:    st <= ST_IDLE;
        endcase
      end else begin
        case (st)
          ST_CONT: if (take) begin
            pair_period <= meas;
            pair_high   <= hi_held;
            pair_stb    <= 1'b1;
          end
          ST_BURST: if (b_done) begin
            st        <= ST_BUSY;
            rpt_valid <= 1'b1;
          end
          ST_BUSY: if (rpt_ready) begin
            st        <= ST_IDLE;
            rpt_valid <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy        = (st == ST_BURST) || (st == ST_BUSY);
  assign rpt_clk_mhz = MHZ_W'(CLK_MHZ);
endmodule

// File: rtl/pwm_meter_chk.sv
`timescale 1ns/1ps
module pwm_meter_chk
  import pwm_meter_pkg::*;
#(
  parameter int BCNT_W = 16,
  parameter int ACC_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input state_e            st,
  input logic              pair_stb,
  input logic              busy,
  input logic              rpt_valid,
  input logic              rpt_ready,
  input logic [BCNT_W-1:0] rpt_count,
  input logic [ACC_W-1:0]  rpt_period_sum,
  input logic [ACC_W-1:0]  rpt_high_sum
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_ready |=> rpt_valid && $stable(rpt_count)
      && $stable(rpt_period_sum) && $stable(rpt_high_sum));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && rpt_ready |=> !rpt_valid && !busy);

  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> busy);

  p_stb_cont_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> $past(st) == ST_CONT);

  p_count_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> rpt_count != '0);
endmodule

bind pwm_meter pwm_meter_chk #(.BCNT_W(BCNT_W), .ACC_W(ACC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st            (st),
  .pair_stb      (pair_stb),
  .busy          (busy),
  .rpt_valid     (rpt_valid),
  .rpt_ready     (rpt_ready),
  .rpt_count     (rpt_count),
  .rpt_period_sum(rpt_period_sum),
  .rpt_high_sum  (rpt_high_sum)
);

// File: tb/sim_pwm_meter.sv
`timescale 1ns/1ps
module sim_pwm_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic        swap_sel = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [15:0] burst_target = '0;
  logic        rpt_ready = 1'b0;
  logic [31:0] pair_period, pair_high;
  logic        pair_stb, busy, rpt_valid;
  logic [15:0] rpt_count;
  logic [63:0] rpt_period_sum, rpt_high_sum;
  logic [15:0] rpt_clk_mhz;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  // waveform generator settings
  bit gen_en = 0;
  int gp = 4, gh = 2, gd = 0;

  always #2.5 clk = ~clk;

  pwm_meter u0 (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .swap_sel(swap_sel),
    .mode_sel(mode_sel), .burst_target(burst_target),
    .pair_period(pair_period), .pair_high(pair_high), .pair_stb(pair_stb),
    .busy(busy), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_count(rpt_count), .rpt_period_sum(rpt_period_sum),
    .rpt_high_sum(rpt_high_sum), .rpt_clk_mhz(rpt_clk_mhz)
  );

  // pin_a: high for gh of every gp cycles; pin_b: same shape, gd cycles later
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (gen_en) begin
        if (ph >= gp) ph = 0;
        pin_a = (ph < gh);
        pin_b = (((ph + gp - gd) % gp) < gh);
        ph = (ph + 1 == gp) ? 0 : ph + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wait_report(input string req);
    int k;
    k = 0;
    while (!rpt_valid && k < 3000) begin
      tick(1);
      k++;
    end
    chk({req, " report raised"}, rpt_valid, 1);
  endtask

  // Run one burst from idle; expects a count and totals computed from period and high time.
  task automatic burst(input int n, input int p, input int h, input string req);
    int eff;
    eff = (n == 0) ? 1 : n;
    mode_sel = 2'd0;
    gp = p; gh = h; gd = 0; gen_en = 1;
    tick(3 * p + 4);
    burst_target = 16'(n);
    mode_sel = 2'd2;
    wait_report(req);
    chk({req, " count"}, rpt_count, eff);
    chk({req, " period sum"}, rpt_period_sum, 64'(eff * p));
    chk({req, " high sum"}, rpt_high_sum, 64'(eff * h));
    rpt_ready = 1'b1;
    tick(1);
    rpt_ready = 1'b0;
    chk("R7 valid low after handshake", rpt_valid, 0);
    chk("R7 busy low after handshake", busy, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] s_cnt, s_ps, s_hs;
    logic [31:0] s_p, s_h;
    int stbs;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    chk("R1 pair_period", pair_period, 0);
    chk("R1 pair_high", pair_high, 0);
    chk("R1 pair_stb", pair_stb, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rpt_valid", rpt_valid, 0);
    // R11
    chk("R11 clock MHz", rpt_clk_mhz, 200);

    // R2 latency: rise sampled at edge k, pair updates at edge k+2
    mode_sel = 2'd1;
    tick(6);
    pin_a = 1'b1; pin_b = 1'b1;
    tick(1);
    tick(1);
    chk("R2 no strobe one edge after sampling", pair_stb, 0);
    tick(1);
    chk("R2 strobe two edges after sampling", pair_stb, 1);

    // R2 basic, then R4 idle holds values
    gp = 7; gh = 3; gd = 0; gen_en = 1;
    tick(40);
    chk("R2 period 7", pair_period, 7);
    chk("R2 high 3", pair_high, 3);
    mode_sel = 2'd0;
    tick(3);
    s_p = pair_period; s_h = pair_high;
    gp = 5; gh = 1;
    stbs = 0;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      if (pair_stb) stbs++;
      if (rpt_valid) stbs++;
    end
    chk("R4 no strobe or report in idle", stbs, 0);
    chk("R4 period held in idle", pair_period, s_p);
    chk("R4 high held in idle", pair_high, s_h);

    // R3: entry into continuous clears the pair
    gen_en = 0; pin_a = 1'b0; pin_b = 1'b0;
    tick(5);
    mode_sel = 2'd1;
    tick(1);
    chk("R3 period cleared on entry", pair_period, 0);
    chk("R3 high cleared on entry", pair_high, 0);

    // R2 sweep
    gen_en = 1;
    for (int p = 2; p <= 9; p++) begin
      for (int h = 1; h < p; h++) begin
        gp = p; gh = h;
        tick(4 * p + 12);
        chk($sformatf("R2 period P=%0d H=%0d", p, h), pair_period, p);
        chk($sformatf("R2 high P=%0d H=%0d", p, h), pair_high, h);
      end
    end

    // R5: pin_b lags pin_a by 2 cycles
    gp = 10; gh = 5; gd = 2; swap_sel = 1'b0;
    tick(60);
    chk("R5 swap0 period", pair_period, 10);
    chk("R5 swap0 high (fall from pin_b)", pair_high, 7);
    swap_sel = 1'b1;
    tick(60);
    chk("R5 swap1 period", pair_period, 10);
    chk("R5 swap1 high (rise from pin_b)", pair_high, 3);
    swap_sel = 1'b0; gd = 0;

    // R6 sweep of burst lengths and shapes
    for (int n = 1; n <= 4; n++) begin
      burst(n, 4, 1, $sformatf("R6 N=%0d P=4", n));
      burst(n, 6, 3, $sformatf("R6 N=%0d P=6", n));
      burst(n, 9, 8, $sformatf("R6 N=%0d P=9", n));
    end

    // R8: mode stays burst after completion, no second report
    stbs = 0;
    for (int i = 0; i < 80; i++) begin
      tick(1);
      if (rpt_valid || busy) stbs++;
    end
    chk("R8 no re-arm while mode held", stbs, 0);

    // R9: zero target
    burst(0, 5, 2, "R9 target zero");

    // R7 back-pressure and R10 deferred mode change
    mode_sel = 2'd0;
    tick(4);
    burst_target = 16'd2;
    mode_sel = 2'd2;
    wait_report("R7 backpressure");
    s_cnt = rpt_count; s_ps = rpt_period_sum; s_hs = rpt_high_sum;
    mode_sel = 2'd0;
    stbs = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (!rpt_valid || !busy || rpt_count != s_cnt[15:0]
          || rpt_period_sum != s_ps || rpt_high_sum != s_hs) stbs++;
    end
    chk("R7 report held under back-pressure", stbs, 0);
    chk("R10 mode change deferred while pending", rpt_valid, 1);
    chk("R7 totals", rpt_period_sum, 10);
    mode_sel = 2'd2;
    tick(2);
    mode_sel = 2'd0;
    tick(1);
    rpt_ready = 1'b1;
    tick(1);
    rpt_ready = 1'b0;
    chk("R7 released after handshake", rpt_valid, 0);
    tick(2);
    mode_sel = 2'd2;
    wait_report("R10 re-arm after deferred idle");
    chk("R10 count of new burst", rpt_count, 2);
    chk("R10 high sum of new burst", rpt_high_sum, 4);
    rpt_ready = 1'b1;
    tick(1);
    rpt_ready = 1'b0;
    tick(2);
    finish_run();
  end
endmodule